// File: doc/BRIEF.md
# Buffered Up/Down PWM Timer Channel

This block is one timer channel that turns a free-running 16-bit counter, a period register and a compare (duty) register into a single PWM waveform. Two counting styles are available. In edge style the counter climbs from 1 to the period value and wraps. In center style it climbs from 0 to the period value and then falls back to 0. A polarity select picks whether the output is high or low in the region before the compare point.

Software never writes the duty register directly. Writes go to a shadow buffer, and the buffer is copied into the duty register only at a period boundary. In edge style the boundary is the wrap. In center style it is the underflow to zero. Each boundary sets a sticky event flag, and that flag can raise an interrupt level through an enable.

The period and buffer writes are plain register strobes that are accepted on every clock, with no back-pressure. There is no streaming data path, so there is no valid/ready handshake. When the timer is started, the output keeps its retained level for the first advancing clock.

Top module: `pwm_buffered_timer`

## Requirements
- R1: While `rst_n` is low, `count`, `duty`, `pwm_out`, `count_down` and `period_flag` are all 0.
- R2: In edge style (`center_mode`=0), each clock with `run`=1 and a nonzero period does one of two things. If `count` is at or above the period, it is set to 1. Otherwise it is incremented. One period is therefore exactly `period` clocks long, and `count_down` reads 0.
- R3: In center style (`center_mode`=1), `count` rises by one per clock until it reaches the period and then falls by one per clock. `count_down` is 1 while the counter is falling. The clock that brings `count` to 0 is the underflow, and it clears `count_down`.
- R4: `duty` takes the value the buffer held before the clock, and it does so only on a boundary clock (the edge-style wrap to 1, or the center-style step to 0). A buffer write in any other clock leaves `duty` unchanged until the next boundary.
- R5: In edge style, the active condition is "the new `count` is less than or equal to the new `duty`". With `active_first`=1 the output equals the active condition, and with `active_first`=0 it is the inverse. As a result, a duty of 0 is never active, and a duty equal to the period is always active.
- R6: In center style, the active condition is "the new `duty` is greater than or equal to the period, or the new `count` is below the new `duty`". The polarity rule of R5 applies. The output therefore inverts where `count` crosses `duty`, a duty of 0 gives 0 %, and a duty of at least the period gives 100 %.
- R7: On the first advancing clock after `run` rises, `pwm_out` keeps its previous level. It follows R5 or R6 from the second advancing clock onward.
- R8: While `run` is 0, `count`, `count_down` and `pwm_out` hold their values.
- R9: `period_flag` is set on every boundary clock and stays set until `flag_clr` is 1 on a clock. When a boundary and `flag_clr` fall on the same clock, the flag is left set.
- R10: `irq` is 1 exactly when both `period_flag` and `irq_en` are 1.
- R11: While the period register holds 0, the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start bit; 0 freezes the channel |
| center_mode | input | 1 | 0 = edge style, 1 = center (up/down) style |
| active_first | input | 1 | 1 = output high before the compare point |
| period_we | input | 1 | Write strobe for the period register |
| period_wd | input | 16 | Period write data |
| buf_we | input | 1 | Write strobe for the duty buffer |
| buf_wd | input | 16 | Duty buffer write data |
| flag_clr | input | 1 | Clears the period flag |
| irq_en | input | 1 | Interrupt enable |
| count | output | 16 | Current counter value |
| count_down | output | 1 | Counter falling (center style) |
| duty | output | 16 | Active duty register |
| pwm_out | output | 1 | PWM waveform |
| period_flag | output | 1 | Sticky boundary event flag |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest situation to reach is a clear request landing on the very clock of a boundary. The stimulus gets there by holding `flag_clr` high for several whole periods, so that every boundary in that window collides with a clear.

A second awkward case is the center-style turn when the period is 1. There the step down from the top is also the underflow. The bench reaches it by rewriting the period to 1 while the counter is running.

A behavioural model in the bench tracks count, direction, duty, retained output and flag with plain integers. It is compared with every output on every clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic {
    CNT_EDGE   = 1'b0,
    CNT_CENTER = 1'b1
  } cnt_style_e;
endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  cnt_style_e   style_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         down_q,
  output logic         step_o,
  output logic         bound_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic going_down;
  logic down_nxt;

  always_comb begin
    step_o     = run_i && (period_i != '0);
    going_down = 1'b0;
    cnt_nxt    = cnt_q;
    down_nxt   = down_q;
    bound_o    = 1'b0;
    if (step_o) begin
      if (style_i == CNT_EDGE) begin
        down_nxt = 1'b0;
        if (cnt_q >= period_i) begin
          cnt_nxt = ONE;
          bound_o = 1'b1;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else begin
        going_down = down_q ? (cnt_q != '0) : (cnt_q >= period_i);
        cnt_nxt    = going_down ? cnt_q - ONE : cnt_q + ONE;
        down_nxt   = going_down && (cnt_nxt != '0);
        bound_o    = going_down && (cnt_nxt == '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      down_q <= down_nxt;
    end
  end

  // R2: edge style wraps to 1 after reaching the period
  p_edge_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && style_i == CNT_EDGE && period_i != '0 && cnt_q == period_i) |=> (cnt_q == ONE));

  // R3: center style, falling from 1 reaches 0 and turns upward
  p_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && style_i == CNT_CENTER && period_i != '0 && down_q && cnt_q == ONE) |=> (cnt_q == '0 && !down_q));

  // R8: a stopped counter holds
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> ($stable(cnt_q) && $stable(down_q)));

  // R11: zero period does not advance
  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (period_i == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_duty_buf.sv
module pwm_duty_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         buf_we_i,
  input  logic [W-1:0] buf_wd_i,
  input  logic         load_i,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] duty_nxt
);
  logic [W-1:0] shadow_q;

  assign duty_nxt = load_i ? shadow_q : duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      duty_q   <= '0;
    end else begin
      duty_q <= duty_nxt;
      if (buf_we_i) shadow_q <= buf_wd_i;
    end
  end

  // R4: duty changes only on a boundary clock
  p_duty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(duty_q));
endmodule

// File: rtl/pwm_outgen.sv
module pwm_outgen
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         step_i,
  input  cnt_style_e   style_i,
  input  logic         active_first_i,
  input  logic [W-1:0] cnt_nxt_i,
  input  logic [W-1:0] duty_nxt_i,
  input  logic [W-1:0] period_i,
  output logic         out_q
);
  logic armed_q;
  logic active;
  logic level;

  always_comb begin
    if (style_i == CNT_EDGE) active = (cnt_nxt_i <= duty_nxt_i);
    else                     active = (duty_nxt_i >= period_i) || (cnt_nxt_i < duty_nxt_i);
    level = active_first_i ? active : !active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (step_i && armed_q) out_q <= level;
      if (!run_i)      armed_q <= 1'b0;
      else if (step_i) armed_q <= 1'b1;
    end
  end

  // R7: first advancing clock after start keeps the retained level
  p_start_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !armed_q) |=> $stable(out_q));

  // R5: edge style, zero duty with high-active polarity is never active
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && armed_q && style_i == CNT_EDGE && active_first_i && duty_nxt_i == '0) |=> !out_q);
endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer
  import pwm_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         center_mode,
  input  logic         active_first,
  input  logic         period_we,
  input  logic [15:0]  period_wd,
  input  logic         buf_we,
  input  logic [15:0]  buf_wd,
  input  logic         flag_clr,
  input  logic         irq_en,
  output logic [15:0]  count,
  output logic         count_down,
  output logic [15:0]  duty,
  output logic         pwm_out,
  output logic         period_flag,
  output logic         irq
);
  cnt_style_e   style;
  logic [W-1:0] period_q;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic [W-1:0] duty_q;
  logic [W-1:0] duty_nxt;
  logic         step;
  logic         bound;
  logic         flag_q;

  assign style = center_mode ? CNT_CENTER : CNT_EDGE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) period_q <= '0;
    else if (period_we) period_q <= W'(period_wd);
  end

  pwm_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(run), .style_i(style), .period_i(period_q),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .down_q(count_down), .step_o(step), .bound_o(bound)
  );

  pwm_duty_buf #(.W(W)) u_duty (
    .clk(clk), .rst_n(rst_n), .buf_we_i(buf_we), .buf_wd_i(W'(buf_wd)),
    .load_i(bound), .duty_q(duty_q), .duty_nxt(duty_nxt)
  );

  pwm_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(step), .style_i(style),
    .active_first_i(active_first), .cnt_nxt_i(cnt_nxt), .duty_nxt_i(duty_nxt),
    .period_i(period_q), .out_q(pwm_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (bound)    flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assign count       = 16'(cnt_q);
  assign duty        = 16'(duty_q);
  assign period_flag = flag_q;
  assign irq         = flag_q & irq_en;

  // R9: a boundary always leaves the flag set, even against a clear
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bound |=> period_flag);

  // R9: without a clear the flag is sticky
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_flag && !flag_clr) |=> period_flag);

  // R8: stopped channel keeps its output level
  p_out_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(pwm_out));
endmodule

// File: tb/pwm_buffered_timer_tb.sv
module pwm_buffered_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, center_mode = 0, active_first = 1, period_we = 0, buf_we = 0;
  logic flag_clr = 0, irq_en = 0;
  logic [15:0] period_wd = 0, buf_wd = 0;
  logic [15:0] count, duty;
  logic count_down, pwm_out, period_flag, irq;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int m_cnt = 0, m_duty = 0, m_buf = 0, m_per = 0;
  bit m_dn = 0, m_out = 0, m_armed = 0, m_flag = 0, m_held = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_buffered_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .center_mode(center_mode),
    .active_first(active_first), .period_we(period_we), .period_wd(period_wd),
    .buf_we(buf_we), .buf_wd(buf_wd), .flag_clr(flag_clr), .irq_en(irq_en),
    .count(count), .count_down(count_down), .duty(duty), .pwm_out(pwm_out),
    .period_flag(period_flag), .irq(irq)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin : model
    int nx;
    bit bnd, gd, act;
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_duty = 0; m_buf = 0; m_per = 0;
      m_dn = 0; m_out = 0; m_armed = 0; m_flag = 0; m_held = 0;
    end else begin
      bnd = 0;
      m_held = 0;
      nx = m_cnt;
      if (run && m_per != 0) begin
        if (!center_mode) begin
          m_dn = 0;
          if (m_cnt >= m_per) begin nx = 1; bnd = 1; end
          else nx = m_cnt + 1;
        end else begin
          gd = m_dn ? (m_cnt != 0) : (m_cnt >= m_per);
          nx = gd ? m_cnt - 1 : m_cnt + 1;
          m_dn = gd && nx != 0;
          bnd = gd && nx == 0;
        end
        if (bnd) m_duty = m_buf;
        if (!center_mode) act = (nx <= m_duty);
        else act = (m_duty >= m_per) || (nx < m_duty);
        if (m_armed) m_out = active_first ? act : !act;
        else m_held = 1;
        m_armed = 1;
      end
      if (!run) m_armed = 0;
      m_cnt = nx;
      if (bnd) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (buf_we) m_buf = buf_wd;
      if (period_we) m_per = period_wd;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1 count", count, 0);
        chk("R1 duty", duty, 0);
        chk("R1 pwm_out", pwm_out, 0);
        chk("R1 count_down", count_down, 0);
        chk("R1 period_flag", period_flag, 0);
      end else begin
        chk(center_mode ? "R3 count" : "R2 count", count, m_cnt);
        chk("R3 count_down", count_down, m_dn);
        chk("R4 duty", duty, m_duty);
        chk(m_held ? "R7 pwm_out" : (center_mode ? "R6 pwm_out" : "R5 pwm_out"), pwm_out, m_out);
        chk("R9 period_flag", period_flag, m_flag);
        chk("R10 irq", irq, m_flag & irq_en);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      period_we = 0; buf_we = 0;
    end
  endtask

  task automatic wr_period(int v);
    @(negedge clk); #1; period_we = 1; period_wd = 16'(v);
    @(negedge clk); #1; period_we = 0;
  endtask

  task automatic wr_buf(int v);
    @(negedge clk); #1; buf_we = 1; buf_wd = 16'(v);
    @(negedge clk); #1; buf_we = 0;
  endtask

  initial begin : stim
    int snap_c, snap_o;
    step(3);
    rst_n = 1;
    step(2);
    // edge style, period 4
    wr_period(4);
    wr_buf(2);
    irq_en = 1;
    run = 1;
    step(14);
    wr_buf(3);
    step(11);
    flag_clr = 1; step(1); flag_clr = 0;
    wr_buf(4);           // 100 %
    step(12);
    wr_buf(0);           // 0 %
    step(12);
    active_first = 0;
    step(10);
    // R8: freeze
    run = 0;
    step(1);
    snap_c = count; snap_o = pwm_out;
    step(5);
    chk("R8 frozen count", count, snap_c);
    chk("R8 frozen pwm_out", pwm_out, snap_o);
    run = 1;
    step(9);
    // center style
    run = 0; active_first = 1;
    wr_buf(2);
    center_mode = 1;
    run = 1;
    step(30);
    wr_buf(4);
    step(20);
    wr_buf(0);
    step(20);
    wr_buf(3);
    irq_en = 0;
    step(10);
    // R9: clear held across boundaries
    flag_clr = 1;
    step(30);
    flag_clr = 0;
    irq_en = 1;
    step(6);
    // period 1 turn-around
    wr_period(1);
    step(12);
    // R11: zero period
    wr_period(0);
    step(1);
    snap_c = count;
    step(6);
    chk("R11 idle count", count, snap_c);
    // back to edge style with longer period
    wr_period(5);
    center_mode = 0;
    wr_buf(5);
    step(25);
    center_mode = 1;
    step(17);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule